// File: doc/BRIEF.md
# Program-Mode Entry and Protection Controller

This block decides who may touch on-chip nonvolatile storage: the internal processor or an external serial programmer. It watches two asynchronous mode requests, a high-voltage request and a low-voltage entry pin, and moves between normal run, a high-voltage programming session and a low-voltage programming session. The low-voltage path only works while a stored enable bit is set. The same bit tells the pad logic that the shared pin is reserved for mode entry and is not general I/O.

Every access request carries a requester tag (processor or external), an operation and a target region. The block checks it against a small stored set of protection bits and answers one cycle later. The answer is a grant pulse or a deny pulse. A denied read returns zeros. Protection only ever restricts the external requester.

The protection bits and the low-voltage enable bit live inside the block. They are changed by writes to the configuration region, and a whole-block erase puts them back to the erased state.

Top module: `pgm_guard`

Encodings:
- Requester: 0 = processor, 1 = external.
- Operation: 0 = read, 1 = write, 2 = row erase, 3 = whole-block erase.
- Region: 0 = code, 1 = data, 2 = configuration, 3 = identification.
- Mode: 0 = run, 1 = high-voltage session, 2 = low-voltage session.
- Configuration word bits:
  - bit 0: code read/write lock
  - bit 1: data read/write lock
  - bit 2: data write lock
  - bit 3: configuration write lock
  - bit 4: low-voltage enable
  - all other bits: zero

## Requirements
- R1: After reset the mode is 0, grant and deny are low, the read data is zero, the configuration word is 0x10 (all locks clear, low-voltage enable set) and the pin-select output is 1.
- R2: A high-voltage request enters mode 1 on the third rising edge after it is raised, whatever the low-voltage enable bit and the entry pin show. A high-voltage request seen during mode 2 moves the block to mode 1.
- R3: From mode 0, a high entry pin enters mode 2 on the third edge only while the low-voltage enable bit is 1. With the bit at 0 the block stays in mode 0. The pin-select output always equals the low-voltage enable bit.
- R4: A programming session ends only after both synchronized requests have been low on two consecutive edges. That is the fourth edge after the last request falls. A one-cycle low pulse does not end the session.
- R5: Processor reads, writes and row erases are granted in every mode and under every lock setting. A processor whole-block erase is denied.
- R6: Every external request made in mode 0 is denied.
- R7: In a session, an external read is handled as follows:
  - code reads are denied when bit 0 is set;
  - data reads are denied when bit 1 is set;
  - configuration and identification reads are always granted.
- R8: In a session, an external write is handled as follows:
  - code writes are denied when bit 0 is set;
  - data writes are denied when bit 1 or bit 2 is set;
  - configuration writes are denied when bit 3 is set;
  - identification writes are always granted.
- R9: In a session, an external row erase is denied on exactly the regions that R8 locks against writing. An external whole-block erase is always granted and restores the configuration word to 0x10.
- R10: Each request yields exactly one one-cycle pulse, grant or deny, on the edge after the request. A denied read returns zero data. A denied configuration write leaves the configuration word unchanged.
- R11: A granted processor configuration write changes only bits 0 to 2. A granted external configuration write also changes bit 3. Bit 4 changes only when the write is external and the block is in mode 1.
- R12: A granted read of the configuration region returns the configuration word in the low bits with zero above. Any other granted read returns the memory read data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hv_req_i | input | 1 | Asynchronous high-voltage mode request |
| lv_pin_i | input | 1 | Asynchronous low-voltage entry pin level |
| req_valid_i | input | 1 | Access request strobe, one cycle per request |
| req_src_i | input | 1 | Requester tag |
| req_op_i | input | 2 | Operation code |
| req_region_i | input | 2 | Target region |
| req_wdata_i | input | CFG_W | Write data for configuration writes |
| rd_data_i | input | DW | Read data from the memory arrays |
| gnt_o | output | 1 | Registered grant pulse |
| deny_o | output | 1 | Registered deny (error) pulse |
| rd_data_o | output | DW | Registered read data, zero unless a read was granted |
| mode_o | output | 2 | Current mode |
| pin_sel_o | output | 1 | 1 = shared pin reserved for mode entry, 0 = general I/O |

## Verification
The assertions assume that each request is a single-cycle strobe whose tag, operation, region and data are stable in the cycle it is sampled. They also assume the mode requests are level signals that the block itself synchronizes. The bench drives every request for exactly one cycle from the falling edge and reads the answer on the next falling edge. It changes the mode inputs only between requests, so no request straddles a mode change. Lock patterns are reloaded through an erase and a configuration write before every swept request. A swept request therefore sees a known word, even when that request itself rewrites configuration.

// File: rtl/pgm_guard_pkg.sv
package pgm_guard_pkg;

  typedef enum logic [1:0] {
    OP_READ        = 2'd0,
    OP_WRITE       = 2'd1,
    OP_ROW_ERASE   = 2'd2,
    OP_BLOCK_ERASE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RG_CODE   = 2'd0,
    RG_DATA   = 2'd1,
    RG_CONFIG = 2'd2,
    RG_ID     = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    MODE_RUN = 2'd0,
    MODE_HV  = 2'd1,
    MODE_LV  = 2'd2
  } mode_e;

  // bit 0 code lock, 1 data rw lock, 2 data write lock, 3 config lock, 4 lv enable
  typedef struct packed {
    logic lv_en;
    logic cfg_wlock;
    logic data_wlock;
    logic data_rwlock;
    logic code_rwlock;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
  localparam cfg_t CFG_ERASED = 5'b10000;

  localparam logic SRC_CPU = 1'b0;
  localparam logic SRC_EXT = 1'b1;

endpackage

// File: rtl/pgm_sync.sv
module pgm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pgm_mode_ctl.sv
module pgm_mode_ctl
  import pgm_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  hv_s,
  input  logic  lv_s,
  input  logic  lv_en,
  output mode_e mode_q
);

  logic  idle_now;
  logic  idle_q;
  mode_e mode_d;

  assign idle_now = !hv_s && !lv_s;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (hv_s)               mode_d = MODE_HV;
        else if (lv_en && lv_s) mode_d = MODE_LV;
      end
      MODE_HV: begin
        if (idle_now && idle_q) mode_d = MODE_RUN;
      end
      MODE_LV: begin
        if (hv_s)                    mode_d = MODE_HV;
        else if (idle_now && idle_q) mode_d = MODE_RUN;
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_RUN;
      idle_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      idle_q <= idle_now;
    end
  end

endmodule

// File: rtl/pgm_policy.sv
module pgm_policy
  import pgm_guard_pkg::*;
(
  input  mode_e   mode,
  input  cfg_t    cfg,
  input  logic    src,
  input  op_e     op,
  input  region_e region,
  output logic    allow
);

  logic read_lock;
  logic write_lock;

  always_comb begin
    unique case (region)
      RG_CODE:   read_lock = cfg.code_rwlock;
      RG_DATA:   read_lock = cfg.data_rwlock;
      default:   read_lock = 1'b0;
    endcase
    unique case (region)
      RG_CODE:   write_lock = cfg.code_rwlock;
      RG_DATA:   write_lock = cfg.data_rwlock | cfg.data_wlock;
      RG_CONFIG: write_lock = cfg.cfg_wlock;
      default:   write_lock = 1'b0;
    endcase
  end

  always_comb begin
    if (src == SRC_CPU) begin
      allow = (op != OP_BLOCK_ERASE);
    end else if (mode == MODE_RUN) begin
      allow = 1'b0;
    end else begin
      unique case (op)
        OP_READ:        allow = !read_lock;
        OP_WRITE:       allow = !write_lock;
        OP_ROW_ERASE:   allow = !write_lock;
        OP_BLOCK_ERASE: allow = 1'b1;
        default:        allow = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/pgm_cfg_store.sv
module pgm_cfg_store
  import pgm_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             allow,
  input  logic             src,
  input  op_e              op,
  input  region_e          region,
  input  mode_e            mode,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg_q
);

  cfg_t wr;
  logic do_erase;
  logic do_write;

  assign wr       = cfg_t'(wdata);
  assign do_erase = valid && allow && (op == OP_BLOCK_ERASE);
  assign do_write = valid && allow && (op == OP_WRITE) && (region == RG_CONFIG);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_ERASED;
    end else if (do_erase) begin
      cfg_q <= CFG_ERASED;
    end else if (do_write) begin
      cfg_q.code_rwlock <= wr.code_rwlock;
      cfg_q.data_rwlock <= wr.data_rwlock;
      cfg_q.data_wlock  <= wr.data_wlock;
      if (src == SRC_EXT) begin
        cfg_q.cfg_wlock <= wr.cfg_wlock;
        if (mode == MODE_HV) cfg_q.lv_en <= wr.lv_en;
      end
    end
  end

endmodule

// File: rtl/pgm_guard.sv
module pgm_guard
  import pgm_guard_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hv_req_i,
  input  logic             lv_pin_i,
  input  logic             req_valid_i,
  input  logic             req_src_i,
  input  logic [1:0]       req_op_i,
  input  logic [1:0]       req_region_i,
  input  logic [CFG_W-1:0] req_wdata_i,
  input  logic [DW-1:0]    rd_data_i,
  output logic             gnt_o,
  output logic             deny_o,
  output logic [DW-1:0]    rd_data_o,
  output logic [1:0]       mode_o,
  output logic             pin_sel_o
);

  localparam int PAD_W = DW - CFG_W;

  logic [1:0] req_s;
  logic       hv_s;
  logic       lv_s;
  mode_e      mode_q;
  cfg_t       cfg_q;
  op_e        op;
  region_e    region;
  logic       allow;
  logic [DW-1:0] rd_sel;

  assign op     = op_e'(req_op_i);
  assign region = region_e'(req_region_i);

  pgm_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d_i ({hv_req_i, lv_pin_i}),
    .q_o (req_s)
  );
  assign hv_s = req_s[1];
  assign lv_s = req_s[0];

  pgm_mode_ctl mode_i (
    .clk    (clk),
    .rst    (rst),
    .hv_s   (hv_s),
    .lv_s   (lv_s),
    .lv_en  (cfg_q.lv_en),
    .mode_q (mode_q)
  );

  pgm_policy policy_i (
    .mode   (mode_q),
    .cfg    (cfg_q),
    .src    (req_src_i),
    .op     (op),
    .region (region),
    .allow  (allow)
  );

  pgm_cfg_store cfg_i (
    .clk    (clk),
    .rst    (rst),
    .valid  (req_valid_i),
    .allow  (allow),
    .src    (req_src_i),
    .op     (op),
    .region (region),
    .mode   (mode_q),
    .wdata  (req_wdata_i),
    .cfg_q  (cfg_q)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_sel = (region == RG_CONFIG) ? {{PAD_W{1'b0}}, cfg_q} : rd_data_i;
    end else begin : g_nopad
      assign rd_sel = (region == RG_CONFIG) ? cfg_q[DW-1:0] : rd_data_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_o     <= 1'b0;
      deny_o    <= 1'b0;
      rd_data_o <= '0;
    end else begin
      gnt_o     <= req_valid_i && allow;
      deny_o    <= req_valid_i && !allow;
      rd_data_o <= (req_valid_i && allow && op == OP_READ) ? rd_sel : '0;
    end
  end

  assign mode_o    = mode_q;
  assign pin_sel_o = cfg_q.lv_en;

endmodule

// File: rtl/pgm_guard_chk.sv
module pgm_guard_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid_i,
  input logic          req_src_i,
  input logic [1:0]    req_op_i,
  input logic          gnt_o,
  input logic          deny_o,
  input logic [DW-1:0] rd_data_o,
  input logic [1:0]    mode_q,
  input logic [4:0]    cfg_q,
  input logic          hv_s,
  input logic          lv_s
);

  // R10
  one_answer_chk: assert property (@(posedge clk) disable iff (rst)
    !(gnt_o && deny_o));

  // R10
  deny_zero_chk: assert property (@(posedge clk) disable iff (rst)
    deny_o |-> (rd_data_o == '0));

  // R5
  cpu_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !req_src_i && req_op_i != 2'd3) |=> gnt_o);

  // R6
  ext_run_deny_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_src_i && mode_q == 2'd0) |=> deny_o);

  // R2
  hv_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd0 && hv_s) |=> (mode_q == 2'd1));

  // R3
  lv_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd2 && $past(mode_q) == 2'd0) |-> $past(cfg_q[4]));

  // R4
  exit_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd0 && $past(mode_q) != 2'd0) |-> (!$past(hv_s) && !$past(lv_s)));

  // R11
  cfg_lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q[3]) |-> ($past(mode_q) != 2'd0));

  // R11
  lv_en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q[4]) |-> ($past(mode_q) == 2'd1));

endmodule

bind pgm_guard pgm_guard_chk #(.DW(DW)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_valid_i (req_valid_i),
  .req_src_i   (req_src_i),
  .req_op_i    (req_op_i),
  .gnt_o       (gnt_o),
  .deny_o      (deny_o),
  .rd_data_o   (rd_data_o),
  .mode_q      (mode_q),
  .cfg_q       (cfg_q),
  .hv_s        (hv_s),
  .lv_s        (lv_s)
);

// File: tb/pgm_guard_tb_top.sv
`timescale 1ns/1ps
module pgm_guard_tb_top;

  localparam int DW = 8;
  localparam logic [7:0] MEM_DATA = 8'hA5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hv_req_i = 1'b0;
  logic       lv_pin_i = 1'b0;
  logic       req_valid_i = 1'b0;
  logic       req_src_i = 1'b0;
  logic [1:0] req_op_i = 2'd0;
  logic [1:0] req_region_i = 2'd0;
  logic [4:0] req_wdata_i = 5'd0;
  logic [DW-1:0] rd_data_i = MEM_DATA;
  logic       gnt_o;
  logic       deny_o;
  logic [DW-1:0] rd_data_o;
  logic [1:0] mode_o;
  logic       pin_sel_o;

  int checks = 0;
  int failures = 0;
  logic r_gnt, r_deny;
  logic [7:0] r_rd;

  always #2 clk = ~clk;

  pgm_guard #(.DW(DW)) dut_i (
    .clk (clk), .rst (rst), .hv_req_i (hv_req_i), .lv_pin_i (lv_pin_i),
    .req_valid_i (req_valid_i), .req_src_i (req_src_i), .req_op_i (req_op_i),
    .req_region_i (req_region_i), .req_wdata_i (req_wdata_i), .rd_data_i (rd_data_i),
    .gnt_o (gnt_o), .deny_o (deny_o), .rd_data_o (rd_data_o),
    .mode_o (mode_o), .pin_sel_o (pin_sel_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_req(input logic s, input logic [1:0] o, input logic [1:0] r,
                        input logic [4:0] wd);
    @(negedge clk);
    req_valid_i = 1'b1; req_src_i = s; req_op_i = o; req_region_i = r; req_wdata_i = wd;
    @(negedge clk);
    req_valid_i = 1'b0;
    r_gnt = gnt_o; r_deny = deny_o; r_rd = rd_data_o;
  endtask

  task automatic read_cfg(output logic [7:0] v);
    do_req(1'b0, 2'd0, 2'd2, 5'd0);
    v = r_rd;
  endtask

  function automatic logic exp_allow(logic s, logic [1:0] o, logic [1:0] r,
                                     logic [1:0] m, logic [4:0] c);
    logic wlock;
    logic rlock;
    wlock = (r == 2'd0) ? c[0] : (r == 2'd1) ? (c[1] | c[2]) : (r == 2'd2) ? c[3] : 1'b0;
    rlock = (r == 2'd0) ? c[0] : (r == 2'd1) ? c[1] : 1'b0;
    if (!s) return o != 2'd3;
    if (m == 2'd0) return 1'b0;
    if (o == 2'd3) return 1'b1;
    if (o == 2'd0) return !rlock;
    return !wlock;
  endfunction

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode_o, 0);
    chk("R1 gnt/deny", {gnt_o, deny_o}, 0);
    chk("R1 rd", rd_data_o, 0);
    chk("R1 pin_sel", pin_sel_o, 1);
    read_cfg(v);
    chk("R1 R12 cfg word", v, 8'h10);

    // R6 external request in run mode
    do_req(1'b1, 2'd0, 2'd3, 5'd0);
    chk("R6 ext read denied", {r_gnt, r_deny}, 2'b01);
    chk("R10 denied read zero", r_rd, 0);

    // R3 low-voltage entry
    lv_pin_i = 1'b1;
    cycles(2);
    chk("R3 not yet in lv", mode_o, 0);
    cycles(1);
    chk("R3 lv entry", mode_o, 2);

    // R11 lv_en not changeable in lv session
    do_req(1'b1, 2'd1, 2'd2, 5'd0);
    chk("R11 ext cfg write granted", r_gnt, 1);
    read_cfg(v);
    chk("R11 lv_en kept in lv session", v, 8'h10);

    // R4 exit timing
    lv_pin_i = 1'b0;
    cycles(3);
    chk("R4 still in session", mode_o, 2);
    cycles(1);
    chk("R4 exit", mode_o, 0);

    // R2 hv entry wins over pin
    hv_req_i = 1'b1; lv_pin_i = 1'b1;
    cycles(3);
    chk("R2 hv entry", mode_o, 1);
    lv_pin_i = 1'b0;
    cycles(3);
    hv_req_i = 1'b0;
    cycles(1);
    hv_req_i = 1'b1;
    cycles(6);
    chk("R4 one-cycle gap kept session", mode_o, 1);

    // sweep of locks x requester x op x region in hv session
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 2; s++) begin
        for (int o = 0; o < 3; o++) begin
          for (int r = 0; r < 4; r++) begin
            logic [4:0] cw;
            logic ea;
            string tag;
            cw = {1'b1, 4'(c)};
            do_req(1'b1, 2'd3, 2'd0, 5'd0);
            do_req(1'b1, 2'd1, 2'd2, cw);
            do_req(1'(s), 2'(o), 2'(r), cw);
            ea = exp_allow(1'(s), 2'(o), 2'(r), 2'd1, cw);
            tag = (s == 0) ? "R5" : (o == 0) ? "R7" : (o == 1) ? "R8" : "R9";
            chk({tag, " grant/deny"}, {r_gnt, r_deny}, {ea, !ea});
            chk({tag, " R12 rd data"}, r_rd,
                (ea && o == 0) ? ((r == 2) ? {3'b0, cw} : MEM_DATA) : 8'h00);
          end
        end
      end
    end

    // R11 lv_en cleared in hv session; processor write limited to low bits
    do_req(1'b1, 2'd3, 2'd0, 5'd0);
    do_req(1'b1, 2'd1, 2'd2, 5'h00);
    read_cfg(v);
    chk("R11 hv clears lv_en", v, 8'h00);
    chk("R3 pin_sel follows lv_en", pin_sel_o, 0);
    do_req(1'b0, 2'd1, 2'd2, 5'h1F);
    read_cfg(v);
    chk("R11 cpu cfg write low bits only", v, 8'h07);
    do_req(1'b0, 2'd3, 2'd0, 5'd0);
    chk("R9 cpu block erase denied", {r_gnt, r_deny}, 2'b01);
    read_cfg(v);
    chk("R9 cfg unchanged after denied erase", v, 8'h07);

    // R10 denied config write leaves word unchanged
    do_req(1'b1, 2'd1, 2'd2, 5'h08);
    read_cfg(v);
    chk("R8 cfg lock set", v, 8'h08);
    do_req(1'b1, 2'd1, 2'd2, 5'h00);
    chk("R8 locked cfg write denied", {r_gnt, r_deny}, 2'b01);
    read_cfg(v);
    chk("R10 cfg unchanged after denial", v, 8'h08);
    do_req(1'b1, 2'd3, 2'd1, 5'd0);
    read_cfg(v);
    chk("R9 block erase restores", v, 8'h10);

    // R3 low-voltage entry blocked with lv_en clear
    do_req(1'b1, 2'd1, 2'd2, 5'h00);
    hv_req_i = 1'b0;
    cycles(6);
    chk("R4 hv session ended", mode_o, 0);
    lv_pin_i = 1'b1;
    cycles(6);
    chk("R3 lv entry blocked", mode_o, 0);
    do_req(1'b1, 2'd0, 2'd3, 5'd0);
    chk("R6 ext id read denied in run", {r_gnt, r_deny}, 2'b01);
    lv_pin_i = 1'b0;

    // R2 hv entry regardless of lv_en clear, then lv->hv is not needed
    hv_req_i = 1'b1;
    cycles(3);
    chk("R2 hv entry with lv_en clear", mode_o, 1);
    hv_req_i = 1'b0;
    cycles(6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule